// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block generates the serial clock for one master on a shared, wired-AND two-wire bus. It times a programmed low period and a programmed high period in system-clock cycles. It also watches the bus clock level through a two-flop synchronizer. Any master holding the line low forces the whole bus low. Because of that, the block waits while the bus is still held low after its own release. It also abandons its high period as soon as another master pulls the line down. Together these give one combined clock: the longest low period and the shortest high period among the masters present.

A master-mode flag gates the clock generator. A one-cycle request sets the flag. Hardware clears it when a stop condition is reported or arbitration is lost. The generator then releases the line and goes idle. The block produces one-cycle strobes on each synchronized rising and falling edge of the bus clock. A data shifter uses the rising strobe to sample data and the falling strobe to change data. Data shifting, address matching and start/stop generation are handled outside this block.

Top module: `scl_clock_sync`

## Requirements
- R1: While reset is asserted, `sclPullLow`, `sclRise`, `sclFall` and `masterActive` are all 0. The synchronizer reads the bus as high.
- R2: A `masterSet` pulse sets `masterActive` on the next clock edge. `stopDet` or `arbLost` clears it on the next edge, and a clear wins over a set that arrives in the same cycle.
- R3: Once `masterActive` is 0, `sclPullLow` is 0 no later than one clock edge later. It stays 0 until the flag is set again.
- R4: Each low phase drives `sclPullLow` to 1 for exactly max(L,2) cycles, where L is the latched `lowWidth`. Values of 0 and 1 act as 2.
- R5: After its own low phase ends, the block keeps the line released and does not start its high count while the synchronized bus still reads low.
- R6: The high count begins on the edge that first sees the synchronized bus high and runs for max(H,2) cycles, where H is the latched `highWidth`. With no other master, a bus-high period therefore lasts max(H,2)+3 cycles.
- R7: If the synchronized bus reads low during the high count, the block starts a new low phase on the next edge. The high count restarts from zero later.
- R8: `lowWidth` and `highWidth` are latched only when a low phase starts. Changes take effect from the next low phase.
- R9: `sclRise` (`sclFall`) is a one-cycle pulse in the cycle after the second synchronizer stage first reads 1 (0). A change on `sclIn` shows on a strobe after two clock edges.
- R10: With a second master on the same line, every bus-low period lasts at least the larger of the two low widths. Every bus-high period lasts at most the smaller high width plus 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterSet | input | 1 | One-cycle request to enter master mode |
| stopDet | input | 1 | Stop condition seen on the bus; clears master mode |
| arbLost | input | 1 | Arbitration lost; clears master mode |
| lowWidth | input | 8 | Programmed low period in clock cycles |
| highWidth | input | 8 | Programmed high period in clock cycles |
| sclIn | input | 1 | Bus SCL level (asynchronous) |
| sclPullLow | output | 1 | Open-drain request: 1 pulls the bus SCL low |
| sclRise | output | 1 | One-cycle strobe on a synchronized bus rising edge |
| sclFall | output | 1 | One-cycle strobe on a synchronized bus falling edge |
| masterActive | output | 1 | Master-mode flag |

## Verification
The block is first run as the only master with several width settings. These include values below the minimum, so exact low and high lengths separate correct counting and clamping from off-by-one or unclamped counting. A changed setting is applied mid-phase to show that it waits for the next low phase. An external hold is applied right after the block releases the line, which shows whether the high count waits for the line instead of starting on release. A behavioural second master with a longer low and a shorter high then shares the line: a design that ignores the bus during its high phase, or starts counting early, breaks the combined-clock bounds. Stop, lost-arbitration and simultaneous set-and-clear pulses exercise the master-mode flag, while a per-cycle reference model compares every output.

// File: rtl/sclsync_pkg.sv
package sclsync_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic latchWidths;
  } ctlStrobe_t;

endpackage

// File: rtl/sclsync_dp.sv
module sclsync_dp
  import sclsync_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   ctl,
  input  logic [W-1:0] lowWidth,
  input  logic [W-1:0] highWidth,
  input  logic         sclIn,
  output logic         busHi,
  output logic         lowDone,
  output logic         highDone,
  output logic         sclRise,
  output logic         sclFall,
  output logic [W-1:0] cnt,
  output logic [W-1:0] loLat,
  output logic [W-1:0] hiLat
);

  localparam logic [W-1:0] MIN_W = W'(2);
  localparam logic [W-1:0] ONE_W = W'(1);

  function automatic logic [W-1:0] clampW(input logic [W-1:0] v);
    return (v < MIN_W) ? MIN_W : v;
  endfunction

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   busPrev;

  // Bus idles high, so the synchronizer resets to ones
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= sclIn;
      end
    end
  endgenerate

  assign busHi = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busPrev <= 1'b1;
    else       busPrev <= busHi;
  end

  assign sclRise = busHi & ~busPrev;
  assign sclFall = ~busHi & busPrev;

  // Phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.cntClr)  cnt <= '0;
    else if (ctl.cntInc)  cnt <= cnt + ONE_W;
  end

  // Width latches, refreshed at the start of each low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loLat <= MIN_W;
      hiLat <= MIN_W;
    end else if (ctl.latchWidths) begin
      loLat <= clampW(lowWidth);
      hiLat <= clampW(highWidth);
    end
  end

  assign lowDone  = (cnt == loLat - ONE_W);
  assign highDone = (cnt == hiLat - ONE_W);

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchWidths |=> ($stable(loLat) && $stable(hiLat))); // R8

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sclRise |=> !sclRise); // R9

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sclFall |=> !sclFall); // R9

endmodule

// File: rtl/sclsync_ctrl.sv
module sclsync_ctrl
  import sclsync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterSet,
  input  logic       stopDet,
  input  logic       arbLost,
  input  logic       busHi,
  input  logic       lowDone,
  input  logic       highDone,
  output ctlStrobe_t ctl,
  output phase_t     phase,
  output logic       masterFlag,
  output logic       pullLow
);

  phase_t phaseNxt;

  // Master-mode flag: clear requests dominate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   masterFlag <= 1'b0;
    else if (stopDet || arbLost) masterFlag <= 1'b0;
    else if (masterSet)          masterFlag <= 1'b1;
  end

  always_comb begin
    ctl      = '0;
    phaseNxt = phase;
    if (!masterFlag) begin
      phaseNxt   = PH_IDLE;
      ctl.cntClr = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNxt        = PH_LOW;
          ctl.cntClr      = 1'b1;
          ctl.latchWidths = 1'b1;
        end
        PH_LOW: begin
          if (lowDone) begin
            phaseNxt   = PH_WAIT;
            ctl.cntClr = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        PH_WAIT: begin
          // Line released; hold off until the bus really reads high
          if (busHi) begin
            phaseNxt   = PH_HIGH;
            ctl.cntClr = 1'b1;
          end
        end
        PH_HIGH: begin
          if (!busHi || highDone) begin
            phaseNxt        = PH_LOW;
            ctl.cntClr      = 1'b1;
            ctl.latchWidths = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        default: begin
          phaseNxt   = PH_IDLE;
          ctl.cntClr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign pullLow = (phase == PH_LOW);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet || arbLost) |=> !masterFlag); // R2

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !masterFlag |=> (phase == PH_IDLE)); // R3

  AST_HIGH_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_HIGH) && ($past(phase) == PH_WAIT)) |-> $past(busHi)); // R5

  AST_ABORT_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_HIGH) && !busHi && masterFlag) |=> (phase == PH_LOW)); // R7

endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync
  import sclsync_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         masterSet,
  input  logic         stopDet,
  input  logic         arbLost,
  input  logic [W-1:0] lowWidth,
  input  logic [W-1:0] highWidth,
  input  logic         sclIn,
  output logic         sclPullLow,
  output logic         sclRise,
  output logic         sclFall,
  output logic         masterActive
);

  ctlStrobe_t   ctl;
  phase_t       phase;
  logic         busHi;
  logic         lowDone;
  logic         highDone;
  logic [W-1:0] cnt;
  logic [W-1:0] loLat;
  logic [W-1:0] hiLat;

  sclsync_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .masterSet  (masterSet),
    .stopDet    (stopDet),
    .arbLost    (arbLost),
    .busHi      (busHi),
    .lowDone    (lowDone),
    .highDone   (highDone),
    .ctl        (ctl),
    .phase      (phase),
    .masterFlag (masterActive),
    .pullLow    (sclPullLow)
  );

  sclsync_dp #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .lowWidth  (lowWidth),
    .highWidth (highWidth),
    .sclIn     (sclIn),
    .busHi     (busHi),
    .lowDone   (lowDone),
    .highDone  (highDone),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .cnt       (cnt),
    .loLat     (loLat),
    .hiLat     (hiLat)
  );

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOW) |-> (cnt < loLat)); // R4

  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH) |-> (cnt < hiLat)); // R6

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (loLat >= W'(2)) && (hiLat >= W'(2))); // R4

endmodule

// File: tb/scl_clock_sync_tb.sv
module scl_clock_sync_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterSet = 1'b0;
  logic       stopDet = 1'b0;
  logic       arbLost = 1'b0;
  logic [7:0] lowWidth = 8'd5;
  logic [7:0] highWidth = 8'd6;
  logic       sclIn;
  logic       sclPullLow, sclRise, sclFall, masterActive;

  // Second master and external hold
  logic bPull = 1'b0;
  logic bEn = 1'b0;
  int   bPh = 0;
  int   bLeft = 0;
  int   bLo = 9;
  int   bHi = 4;
  logic extHold = 1'b0;

  int passCnt = 0;
  int failCnt = 0;
  bit cmpEn = 0;

  // Reference model state
  int mS1, mS2, mPrev, mFlag, mPh, mLeft, mLo, mHi;

  // Run measurement
  bit measEn = 0;
  int measMulti = 0;
  int runSkip = 0;
  int runLen = 0;
  logic lastBus = 1'b1;
  int expLo = 5, expHi = 6;

  assign sclIn = ~(sclPullLow | bPull | extHold);

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_clock_sync u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .masterSet    (masterSet),
    .stopDet      (stopDet),
    .arbLost      (arbLost),
    .lowWidth     (lowWidth),
    .highWidth    (highWidth),
    .sclIn        (sclIn),
    .sclPullLow   (sclPullLow),
    .sclRise      (sclRise),
    .sclFall      (sclFall),
    .masterActive (masterActive)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clampW(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // Behavioural reference, counted down per phase
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1; mFlag = 0; mPh = 0; mLeft = 0;
      mLo = 2; mHi = 2;
    end else begin
      automatic int busSeen = mS2;
      automatic int flagNow = mFlag;
      mPrev = mS2; mS2 = mS1; mS1 = int'(sclIn);
      if (stopDet || arbLost) mFlag = 0;
      else if (masterSet)     mFlag = 1;
      if (flagNow == 0) mPh = 0;
      else begin
        case (mPh)
          0: begin
            mLo = clampW(lowWidth); mHi = clampW(highWidth);
            mLeft = mLo; mPh = 1;
          end
          1: if (mLeft == 1) mPh = 2; else mLeft--;
          2: if (busSeen == 1) begin mPh = 3; mLeft = mHi; end
          default: begin
            if (busSeen == 0 || mLeft == 1) begin
              mLo = clampW(lowWidth); mHi = clampW(highWidth);
              mLeft = mLo; mPh = 1;
            end else mLeft--;
          end
        endcase
      end
    end
  end

  // Second master: follows the raw line
  always @(posedge clk) begin
    if (!bEn) begin
      bPull <= 1'b0; bPh <= 0; bLeft <= bLo;
    end else begin
      case (bPh)
        0: begin
          bPull <= 1'b1;
          if (bLeft <= 1) bPh <= 1; else bLeft <= bLeft - 1;
        end
        1: begin
          bPull <= 1'b0;
          if (sclIn && !bPull) begin bPh <= 2; bLeft <= bHi; end
        end
        default: begin
          if (!sclIn || bLeft <= 1) begin
            bPh <= 0; bLeft <= bLo; bPull <= 1'b1;
          end else bLeft <= bLeft - 1;
        end
      endcase
    end
  end

  // Per-cycle comparison: R4, R5, R6, R7, R8 (drive) R9 (strobes) R2 (flag)
  always @(negedge clk) begin
    if (cmpEn && rstN) begin
      automatic bit ok = (sclPullLow == (mPh == 1)) &&
                         (sclRise == (mS2 == 1 && mPrev == 0)) &&
                         (sclFall == (mS2 == 0 && mPrev == 1)) &&
                         (masterActive == (mFlag == 1));
      check(ok, "R4", "cycle compare pull/rise/fall/act",
            {sclPullLow, sclRise, sclFall, masterActive},
            {(mPh == 1), (mS2 == 1 && mPrev == 0), (mS2 == 0 && mPrev == 1), (mFlag == 1)});
    end
  end

  // Bus period measurement: R4 R6 (single master), R10 (two masters)
  always @(negedge clk) begin
    if (sclIn == lastBus) runLen++;
    else begin
      if (measEn) begin
        if (runSkip > 0) runSkip--;
        else if (measMulti == 0) begin
          if (lastBus == 1'b0) check(runLen == expLo, "R4", "bus low length", runLen, expLo);
          else                 check(runLen == expHi + 3, "R6", "bus high length", runLen, expHi + 3);
        end else begin
          if (lastBus == 1'b0)
            check(runLen >= expLo, "R10", "bus low below longest low", runLen, expLo);
          else
            check(runLen <= expHi + 3, "R10", "bus high above shortest high", runLen, expHi + 3);
        end
      end
      runLen = 1;
      lastBus = sclIn;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int multi, input int lo, input int hi, input int n);
    measMulti = multi; expLo = lo; expHi = hi; runSkip = 2; measEn = 1;
    cycles(n);
    measEn = 0;
  endtask

  task automatic runMain;
    int k;
    // R1: reset state
    cycles(3);
    check(!sclPullLow && !sclRise && !sclFall && !masterActive, "R1", "reset outputs",
          {sclPullLow, sclRise, sclFall, masterActive}, 0);
    rstN = 1'b1;
    cmpEn = 1;
    cycles(2);
    check(!sclPullLow, "R3", "idle without master mode", sclPullLow, 0);

    // R2: set master mode
    masterSet = 1'b1; cycles(1); masterSet = 1'b0;
    check(masterActive, "R2", "flag set", masterActive, 1);
    cycles(1);
    check(sclPullLow, "R4", "low phase starts", sclPullLow, 1);

    // R4 R6: single master 5/6
    cycles(10);
    measure(0, 5, 6, 80);

    // R5: external hold right after release
    while (!sclPullLow) @(negedge clk);
    while (sclPullLow) @(negedge clk);
    extHold = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(!sclPullLow, "R5", "no drive while line held", sclPullLow, 0);
    end
    extHold = 1'b0;
    k = 0;
    while (!sclPullLow && k < 40) begin @(negedge clk); k++; end
    check(k == 6 + 3, "R5", "high count starts at bus high", k, 9);

    // R8: change widths mid-phase
    cycles(3);
    lowWidth = 8'd3; highWidth = 8'd2;
    cycles(30);
    measure(0, 3, 2, 60);

    // R4: values below 2 act as 2
    lowWidth = 8'd0; highWidth = 8'd1;
    cycles(30);
    measure(0, 2, 2, 60);

    // R10: second master 9/4 against 5/10
    lowWidth = 8'd5; highWidth = 8'd10;
    cycles(30);
    bEn = 1'b1;
    cycles(30);
    measure(1, 9, 4, 300);

    // R3: lost arbitration drops master mode
    arbLost = 1'b1; cycles(1); arbLost = 1'b0;
    check(!masterActive, "R2", "arbitration loss clears flag", masterActive, 0);
    cycles(1);
    for (int i = 0; i < 25; i++) begin
      check(!sclPullLow, "R3", "released after arbitration loss", sclPullLow, 0);
      @(negedge clk);
    end
    bEn = 1'b0;
    cycles(10);

    // R2: clear wins over set
    masterSet = 1'b1; stopDet = 1'b1; cycles(1);
    masterSet = 1'b0; stopDet = 1'b0;
    check(!masterActive, "R2", "clear wins over set", masterActive, 0);
    cycles(3);
    check(!sclPullLow, "R3", "stays released", sclPullLow, 0);

    // Restart, then stop
    masterSet = 1'b1; cycles(1); masterSet = 1'b0;
    check(masterActive, "R2", "flag set again", masterActive, 1);
    cycles(40);
    stopDet = 1'b1; cycles(1); stopDet = 1'b0;
    check(!masterActive, "R2", "stop clears flag", masterActive, 0);
    cycles(1);
    check(!sclPullLow, "R3", "released after stop", sclPullLow, 0);
    cycles(5);
  endtask

  initial begin
    fork
      runMain();
      begin
        repeat (100000) @(posedge clk);
        failCnt++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule